// File: doc/BRIEF.md
# SPI Serial Byte-Memory Command Engine

This block is the slave side of a small serial memory of 512 bytes that is reached over a four-wire SPI link in clock mode 0 or mode 3. All SPI pins are brought into the system clock domain through synchronizers. The engine then detects the clock and select edges and shifts SI in on each rising serial clock. It decodes one 8-bit instruction per selection, gathers the address and data bytes, and returns read data or status on SO, which it changes only after a falling serial clock. The byte array is held in on-chip registers.

Write-enable changes, status-register writes and page writes are not carried out here. They are handed as one-cycle request pulses to a neighbouring protection and write-timing unit. That unit reports a busy flag, the write-enable flag and the two protection-level bits. Once it has decided to program, it pulses `commit_i`, and the engine then copies its staged page into the array. Page data is staged in an 8-entry buffer with a per-byte valid mask, so a page write may be shorter than a full page or may wrap inside it.

Top module: `spi_eeprom_engine`

## Requirements
- R1: After reset, and whenever chip select has been high for two or more synchronized cycles, `so_en_o` is low and no request pulse is issued.
- R2: Opcode 0000_x110 (bit 3 ignored) pulses `wen_set_o` once. Opcode 0000_x100 pulses `wen_clr_o` once. The rest of that selection is ignored.
- R3: Opcode 0000_x101 streams the status byte MSB first on SO, repeated for as long as the master clocks. The byte is {4'b0000, bp_i[1], bp_i[0], wen_i, 1'b0} when idle and 8'hFF while `busy_i` is high.
- R4: Opcode 0000_x001 followed by one complete byte pulses `sr_wr_o`, with that byte on `sr_data_o`, after chip select rises. Further bytes in the same selection are ignored.
- R5: Opcode 0000_A011 followed by an address byte reads from address {A, byte}. Data leaves MSB first, the address steps by one per byte, and it wraps from 0x1FF to 0x000.
- R6: Opcode 0000_A010, an address byte and N data bytes store byte k at page offset (addr[2:0]+k) mod 8, with address bits 8..3 held. A later byte overwrites an earlier one at the same offset. After chip select rises, `pg_wr_o` pulses once with `pg_addr_o` = page base (low 3 bits zero) and `pg_mask_o` bit j set for each written offset j. A `commit_i` pulse copies the masked bytes into the array.
- R7: If chip select rises while a data byte is only partly shifted in, the write or status-write request of that selection is dropped entirely.
- R8: An opcode whose upper nibble is nonzero, or whose low 3 bits are 111 or 000, locks the interface. SO stays disabled and no request is issued until the next chip-select fall, and the next selection then works normally.
- R9: While `busy_i` is high when the opcode completes, every instruction except read-status is ignored: no pulse is issued and SO is not enabled.
- R10: SO changes only in the cycle after a detected falling serial clock. The same read works in mode 0 (clock idle low) and in mode 3 (clock idle high).
- R11: Serial clock and SI activity while chip select is high changes nothing. A following selection decodes its opcode from its own first eight bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from master |
| cs_n_i | input | 1 | Active-low chip select |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out value |
| so_en_o | output | 1 | Output enable for SO (low = high impedance) |
| busy_i | input | 1 | Write cycle in progress, from write-timing unit |
| wen_i | input | 1 | Write-enable flag, from write-timing unit |
| bp_i | input | 2 | Protection level bits, from write-timing unit |
| commit_i | input | 1 | Copy staged page into the array |
| wen_set_o | output | 1 | Request: set write enable |
| wen_clr_o | output | 1 | Request: clear write enable |
| sr_wr_o | output | 1 | Request: write status byte |
| sr_data_o | output | 8 | Status byte to write |
| pg_wr_o | output | 1 | Request: program staged page |
| pg_addr_o | output | 9 | Base address of staged page |
| pg_mask_o | output | 8 | Valid-byte mask of staged page |

## Verification
A wrong state register or a wrong bit counter shows up within one byte time as a missing or extra request pulse. These pulses are compared in order against an expected queue, so a stray pulse is reported in the cycle it occurs. A fault in the address counter, either at the read wrap point or in the in-page wrap, shows as a wrong byte on SO at the first affected byte of a read-back, or as a wrong `pg_mask_o` when chip select rises. A fault in the output-enable control shows as `so_en_o` being sampled high during a locked, busy or deselected transfer.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_RDAT, ST_STAT, ST_SRIN, ST_WDAT, ST_DONE, ST_LOCK
  } eng_state_e;

  typedef enum logic [2:0] {
    OP_WEN_SET, OP_WEN_CLR, OP_RD_STAT, OP_WR_STAT, OP_READ, OP_WRITE, OP_BAD
  } eng_op_e;

  // upper nibble must be zero; bit 3 is a don't-care or the high address bit
  function automatic eng_op_e decode_op(input logic [7:0] b);
    eng_op_e r;
    if (b[7:4] != 4'b0000) r = OP_BAD;
    else begin
      case (b[2:0])
        3'b110:  r = OP_WEN_SET;
        3'b100:  r = OP_WEN_CLR;
        3'b101:  r = OP_RD_STAT;
        3'b001:  r = OP_WR_STAT;
        3'b011:  r = OP_READ;
        3'b010:  r = OP_WRITE;
        default: r = OP_BAD;
      endcase
    end
    return r;
  endfunction

  function automatic logic [7:0] status_byte(input logic busy, input logic wen,
                                             input logic [1:0] bp);
    return busy ? 8'hFF : {4'b0000, bp, wen, 1'b0};
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic si_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall,
  output logic cs_rise,
  output logic cs_idle,
  output logic si_s
);
  localparam int NPIN = 3;
  localparam logic [NPIN-1:0] RST_VAL = 3'b010;  // {sck, cs_n, si}

  logic [NPIN-1:0] pin_raw, pin_s;
  logic sck_d, cs_d;

  assign pin_raw = {sck_i, cs_n_i, si_i};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], pin_raw[g]};
    end
    assign pin_s[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= pin_s[2];
      cs_d  <= pin_s[1];
    end
  end

  assign sck_rise = pin_s[2] & ~sck_d;
  assign sck_fall = ~pin_s[2] & sck_d;
  assign cs_fall  = ~pin_s[1] & cs_d;
  assign cs_rise  = pin_s[1] & ~cs_d;
  assign cs_idle  = pin_s[1] & cs_d;
  assign si_s     = pin_s[0];
endmodule

// File: rtl/spi_page_store.sv
module spi_page_store #(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              pg_clr,
  input  logic              wb_we,
  input  logic [PAGE_W-1:0] wb_off,
  input  logic [7:0]        wb_data,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] commit_base,
  output logic [(1<<PAGE_W)-1:0] mask_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_W;

  logic [7:0] mem  [DEPTH];
  logic [7:0] pbuf [PAGE_N];
  logic [PAGE_N-1:0] mask;

  for (genvar g = 0; g < PAGE_N; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pbuf[g] <= 8'h00;
        mask[g] <= 1'b0;
      end else if (pg_clr) begin
        mask[g] <= 1'b0;
      end else if (wb_we && wb_off == PAGE_W'(g)) begin
        pbuf[g] <= wb_data;
        mask[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (commit_i) begin
      for (int j = 0; j < PAGE_N; j++)
        if (mask[j]) mem[{commit_base[ADDR_W-1:PAGE_W], PAGE_W'(j)}] <= pbuf[j];
    end
  end

  assign rd_data = mem[rd_addr];
  assign mask_o  = mask;
endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
  import spi_eeprom_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              si_s,
  input  logic              busy_i,
  input  logic              wen_i,
  input  logic [1:0]        bp_i,
  input  logic [7:0]        rd_byte,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              so_o,
  output logic              so_en_o,
  output logic              wen_set_o,
  output logic              wen_clr_o,
  output logic              sr_wr_o,
  output logic [7:0]        sr_data_o,
  output logic              pg_wr_o,
  output logic [ADDR_W-1:0] pg_addr_o,
  output logic              pg_clr,
  output logic              wb_we,
  output logic [PAGE_W-1:0] wb_off,
  output logic [7:0]        wb_data
);
  eng_state_e st;
  logic [2:0]        bitcnt;
  logic [7:0]        sh_in, tx;
  logic [ADDR_W-1:0] addr;
  logic              a_hi, is_read, load_pend, sr_full, wr_any;

  // named internal events
  logic       shifting, byte_done;
  logic [7:0] byte_in;
  eng_op_e    op_now;
  logic       outputting;

  function automatic logic [ADDR_W-1:0] seq_next(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:PAGE_W], a[PAGE_W-1:0] + PAGE_W'(1)};
  endfunction

  assign shifting   = sck_rise && (st inside {ST_OPC, ST_ADDR, ST_RDAT, ST_STAT,
                                              ST_SRIN, ST_WDAT, ST_DONE});
  assign byte_in    = {sh_in[6:0], si_s};
  assign byte_done  = shifting && (bitcnt == 3'd7);
  assign op_now     = decode_op(byte_in);
  assign outputting = st inside {ST_RDAT, ST_STAT};
  assign rd_addr    = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; bitcnt <= '0; sh_in <= '0; tx <= '0; addr <= '0;
      a_hi <= 1'b0; is_read <= 1'b0; load_pend <= 1'b0; sr_full <= 1'b0;
      wr_any <= 1'b0; so_o <= 1'b0; so_en_o <= 1'b0;
      wen_set_o <= 1'b0; wen_clr_o <= 1'b0; sr_wr_o <= 1'b0; sr_data_o <= '0;
      pg_wr_o <= 1'b0; pg_addr_o <= '0; pg_clr <= 1'b0;
      wb_we <= 1'b0; wb_off <= '0; wb_data <= '0;
    end else begin
      wen_set_o <= 1'b0; wen_clr_o <= 1'b0; sr_wr_o <= 1'b0;
      pg_wr_o <= 1'b0; pg_clr <= 1'b0; wb_we <= 1'b0;
      if (cs_rise) begin
        if (st == ST_WDAT && bitcnt == 3'd0 && wr_any) begin
          pg_wr_o   <= 1'b1;
          pg_addr_o <= {addr[ADDR_W-1:PAGE_W], PAGE_W'(0)};
        end
        if (sr_full && bitcnt == 3'd0) sr_wr_o <= 1'b1;
        st <= ST_IDLE; so_en_o <= 1'b0; load_pend <= 1'b0;
      end else if (cs_fall) begin
        st <= ST_OPC; bitcnt <= '0; so_en_o <= 1'b0;
        sr_full <= 1'b0; wr_any <= 1'b0;
      end else begin
        if (shifting) begin
          sh_in  <= byte_in;
          bitcnt <= bitcnt + 3'd1;
        end
        if (byte_done) begin
          case (st)
            ST_OPC: begin
              if (busy_i && op_now != OP_RD_STAT) st <= ST_LOCK;
              else begin
                case (op_now)
                  OP_WEN_SET: begin wen_set_o <= 1'b1; st <= ST_DONE; end
                  OP_WEN_CLR: begin wen_clr_o <= 1'b1; st <= ST_DONE; end
                  OP_RD_STAT: begin st <= ST_STAT; load_pend <= 1'b1; end
                  OP_WR_STAT: st <= ST_SRIN;
                  OP_READ:  begin a_hi <= byte_in[3]; is_read <= 1'b1; st <= ST_ADDR; end
                  OP_WRITE: begin
                    a_hi <= byte_in[3]; is_read <= 1'b0; st <= ST_ADDR; pg_clr <= 1'b1;
                  end
                  default: st <= ST_LOCK;
                endcase
              end
            end
            ST_ADDR: begin
              addr <= ADDR_W'({a_hi, byte_in});
              if (is_read) begin st <= ST_RDAT; load_pend <= 1'b1; end
              else st <= ST_WDAT;
            end
            ST_RDAT, ST_STAT: load_pend <= 1'b1;
            ST_SRIN: begin sr_data_o <= byte_in; sr_full <= 1'b1; st <= ST_DONE; end
            ST_WDAT: begin
              wb_we   <= 1'b1;
              wb_off  <= addr[PAGE_W-1:0];
              wb_data <= byte_in;
              addr    <= page_next(addr);
              wr_any  <= 1'b1;
            end
            default: ;
          endcase
        end
        if (load_pend) begin
          load_pend <= 1'b0;
          if (st == ST_STAT) tx <= status_byte(busy_i, wen_i, bp_i);
          else begin
            tx   <= rd_byte;
            addr <= seq_next(addr);
          end
        end
        if (sck_fall && outputting) begin
          so_o    <= tx[7];
          tx      <= {tx[6:0], 1'b0};
          so_en_o <= 1'b1;
        end
      end
    end
  end

  // R10: SO moves only right after a detected falling serial clock
  a_r10_so_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sck_fall) |-> $stable(so_o));

  // R8: a locked selection never enables SO
  a_r8_lock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOCK) |-> !so_en_o);

  // R7: requests only follow a chip-select rise on a byte boundary
  a_r7_req_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_wr_o || sr_wr_o) |-> ($past(cs_rise) && $past(bitcnt) == 3'd0));

  // R9: a busy opcode cycle yields no write-enable request
  a_r9_busy_no_wen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_i) |-> !(wen_set_o || wen_clr_o));
endmodule

// File: rtl/spi_eeprom_engine.sv
module spi_eeprom_engine #(
  parameter int ADDR_W      = 9,
  parameter int PAGE_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              cs_n_i,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_en_o,
  input  logic              busy_i,
  input  logic              wen_i,
  input  logic [1:0]        bp_i,
  input  logic              commit_i,
  output logic              wen_set_o,
  output logic              wen_clr_o,
  output logic              sr_wr_o,
  output logic [7:0]        sr_data_o,
  output logic              pg_wr_o,
  output logic [ADDR_W-1:0] pg_addr_o,
  output logic [(1<<PAGE_W)-1:0] pg_mask_o
);
  logic sck_rise, sck_fall, cs_fall, cs_rise, cs_idle, si_s;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_byte, wb_data;
  logic              pg_clr, wb_we;
  logic [PAGE_W-1:0] wb_off;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .cs_n_i(cs_n_i), .si_i(si_i),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .cs_idle(cs_idle), .si_s(si_s)
  );

  spi_cmd_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .si_s(si_s),
    .busy_i(busy_i), .wen_i(wen_i), .bp_i(bp_i), .rd_byte(rd_byte),
    .rd_addr(rd_addr), .so_o(so_o), .so_en_o(so_en_o),
    .wen_set_o(wen_set_o), .wen_clr_o(wen_clr_o), .sr_wr_o(sr_wr_o),
    .sr_data_o(sr_data_o), .pg_wr_o(pg_wr_o), .pg_addr_o(pg_addr_o),
    .pg_clr(pg_clr), .wb_we(wb_we), .wb_off(wb_off), .wb_data(wb_data)
  );

  spi_page_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_byte),
    .pg_clr(pg_clr), .wb_we(wb_we), .wb_off(wb_off), .wb_data(wb_data),
    .commit_i(commit_i), .commit_base(pg_addr_o), .mask_o(pg_mask_o)
  );

  // R1: deselected means SO released
  a_r1_so_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |-> !so_en_o);

  // R6: a page request names a page base and at least one byte
  a_r6_page_req_shape: assert property (@(posedge clk) disable iff (!rst_n)
    pg_wr_o |-> (pg_mask_o != '0 && pg_addr_o[PAGE_W-1:0] == '0));
endmodule

// File: tb/spi_eeprom_engine_tb.sv
module spi_eeprom_engine_tb;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic busy = 1'b0, wen = 1'b0, commit = 1'b0;
  logic [1:0] bp = 2'b00;
  logic so, so_en, wen_set, wen_clr, sr_wr, pg_wr;
  logic [7:0] sr_data, pg_mask;
  logic [8:0] pg_addr;

  always #(CLK_P/2) clk = ~clk;

  spi_eeprom_engine u_dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .si_i(si),
    .so_o(so), .so_en_o(so_en), .busy_i(busy), .wen_i(wen), .bp_i(bp),
    .commit_i(commit), .wen_set_o(wen_set), .wen_clr_o(wen_clr),
    .sr_wr_o(sr_wr), .sr_data_o(sr_data), .pg_wr_o(pg_wr),
    .pg_addr_o(pg_addr), .pg_mask_o(pg_mask)
  );

  int n_chk = 0, n_fail = 0;
  bit mode3 = 1'b0;
  bit oe_seen;
  logic [7:0] ref_mem [512];

  typedef struct { int kind; logic [8:0] a; logic [7:0] d; string req; } ev_t;
  ev_t exp_q [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic push(input int kind, input logic [8:0] a, input logic [7:0] d,
                      input string req);
    ev_t e;
    e.kind = kind; e.a = a; e.d = d; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor: kinds 1 set-enable, 2 clear-enable, 3 status write, 4 page write
  always @(negedge clk) begin
    if (rst_n && (wen_set || wen_clr || sr_wr || pg_wr)) begin
      int k;
      logic [8:0] a;
      logic [7:0] d;
      k = wen_set ? 1 : wen_clr ? 2 : sr_wr ? 3 : 4;
      a = pg_wr ? pg_addr : 9'd0;
      d = sr_wr ? sr_data : pg_wr ? pg_mask : 8'd0;
      if (exp_q.size() == 0) chk(1'b0, "R1/R8/R9/R11", "unexpected request kind", 16'(k), 16'd0);
      else begin
        ev_t e;
        e = exp_q.pop_front();
        chk(e.kind == k, e.req, "request kind", 16'(k), 16'(e.kind));
        chk(e.a == a && e.d == d, e.req, "request addr/data", {a[7:0], d}, {e.a[7:0], e.d});
      end
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    @(negedge clk); sck = mode3; wclk(HALF);
    cs_n = 1'b0; wclk(HALF);
    oe_seen = 1'b0;
  endtask

  task automatic desel();
    @(negedge clk);
    if (!mode3) begin sck = 1'b0; wclk(HALF); end
    cs_n = 1'b1; wclk(4*HALF);
  endtask

  task automatic xfer(input logic [7:0] txb, input int nbits, output logic [7:0] rxb);
    rxb = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); sck = 1'b0; si = txb[7-i];
      wclk(HALF);
      rxb[7-i] = so;
      if (so_en) oe_seen = 1'b1;
      sck = 1'b1;
      wclk(HALF);
    end
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] r;
    xfer(b, 8, r);
  endtask

  task automatic do_write(input logic [8:0] a, input int n, input logic [7:0] v0,
                          input bit allow);
    logic [7:0] pb [8];
    logic [7:0] m;
    m = 8'h00;
    for (int k = 0; k < n; k++) begin
      pb[(a[2:0] + k) % 8] = v0 + 8'(k);
      m[(a[2:0] + k) % 8] = 1'b1;
    end
    push(4, {a[8:3], 3'b000}, m, "R6");
    sel(); send({4'b0000, a[8], 3'b010}); send(a[7:0]);
    for (int k = 0; k < n; k++) send(v0 + 8'(k));
    desel();
    wclk(4); busy = 1'b1; wclk(20);
    if (allow) begin
      commit = 1'b1; @(negedge clk); commit = 1'b0;
      for (int j = 0; j < 8; j++) if (m[j]) ref_mem[{a[8:3], 3'(j)}] = pb[j];
    end
    busy = 1'b0; wclk(4);
  endtask

  task automatic do_read(input logic [8:0] a, input int n, input string req);
    logic [7:0] r;
    sel(); send({4'b0000, a[8], 3'b011}); send(a[7:0]);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 8, r);
      chk(r == ref_mem[9'(a + 9'(k))], req, "read byte", 16'(r), 16'(ref_mem[9'(a + 9'(k))]));
    end
    chk(oe_seen, req, "SO enabled during read", 16'(oe_seen), 16'd1);
    desel();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    for (int i = 0; i < 512; i++) ref_mem[i] = 8'h00;
    wclk(5);
    chk(so_en == 1'b0, "R1", "so_en in reset", 16'(so_en), 16'd0);
    rst_n = 1'b1; wclk(10);
    chk(so_en == 1'b0, "R1", "so_en after reset", 16'(so_en), 16'd0);

    // R2: enable set/clear with the don't-care bit set
    push(1, 9'd0, 8'd0, "R2"); sel(); send(8'h0E); send(8'h55); desel();
    push(2, 9'd0, 8'd0, "R2"); sel(); send(8'h0C); desel();

    // R3: status stream, idle and busy
    wen = 1'b1; bp = 2'b10;
    sel(); send(8'h05);
    xfer(8'h00, 8, r); chk(r == 8'h0A, "R3", "status byte 1", 16'(r), 16'h0A);
    xfer(8'h00, 8, r); chk(r == 8'h0A, "R3", "status byte 2", 16'(r), 16'h0A);
    desel();
    chk(so_en == 1'b0, "R1", "so_en after deselect", 16'(so_en), 16'd0);

    // R4: status write with one full byte, extra byte ignored
    push(3, 9'd0, 8'h0C, "R4"); sel(); send(8'h01); send(8'h0C); send(8'hF3); desel();

    // R6: page write wrapping inside page 0x1F8, then page 0x000
    do_write(9'h1FD, 10, 8'h10, 1'b1);
    do_write(9'h000, 3, 8'hA1, 1'b1);
    do_write(9'h042, 2, 8'h77, 1'b0);   // unit refuses: array unchanged
    do_read(9'h040, 4, "R6");

    // R5: read across the top of the array
    do_read(9'h1FB, 9, "R5");

    // R10: same read in mode 3
    mode3 = 1'b1; do_read(9'h1FE, 4, "R10"); mode3 = 1'b0;

    // R7: partial bytes drop the request
    sel(); send(8'h02); send(8'h10); send(8'h99); xfer(8'hFF, 3, r); desel();
    sel(); send(8'h01); xfer(8'h0C, 5, r); desel();
    chk(exp_q.size() == 0, "R7", "no pending request", 16'(exp_q.size()), 16'd0);

    // R8: invalid opcodes lock the selection
    sel(); send(8'h83); send(8'h06); send(8'h00); xfer(8'h00, 8, r); desel();
    chk(oe_seen == 1'b0, "R8", "SO stays off after bad upper nibble", 16'(oe_seen), 16'd0);
    sel(); send(8'h07); send(8'h06); send(8'h05); xfer(8'h00, 8, r); desel();
    chk(oe_seen == 1'b0, "R8", "SO stays off after code 111", 16'(oe_seen), 16'd0);
    push(1, 9'd0, 8'd0, "R8"); sel(); send(8'h06); desel();

    // R9: busy blocks all but status read
    busy = 1'b1;
    sel(); send(8'h06); desel();
    sel(); send(8'h03); send(8'h00); xfer(8'h00, 8, r); desel();
    chk(oe_seen == 1'b0, "R9", "read ignored while busy", 16'(oe_seen), 16'd0);
    sel(); send(8'h05); xfer(8'h00, 8, r); desel();
    chk(r == 8'hFF, "R9", "status while busy", 16'(r), 16'hFF);
    busy = 1'b0; wclk(4);

    // R11: activity while deselected is ignored
    @(negedge clk); si = 1'b1;
    for (int i = 0; i < 11; i++) begin
      @(negedge clk); sck = 1'b1; wclk(HALF); sck = 1'b0; wclk(HALF);
    end
    chk(so_en == 1'b0, "R11", "SO off while deselected", 16'(so_en), 16'd0);
    push(2, 9'd0, 8'd0, "R11"); sel(); send(8'h04); desel();

    wclk(20);
    chk(exp_q.size() == 0, "R2", "all expected requests seen", 16'(exp_q.size()), 16'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule